// File: doc/BRIEF.md
# Branch Confidence Estimator

This block tells the front end of a core whether the direction prediction for a conditional branch can be trusted. A low-confidence verdict marks the branch as hard to predict; the core then forks a second context that follows the other direction, and it drops the wrong path once the branch resolves. The estimator does not learn branch directions. It learns whether earlier predictions were right, using a table of small saturating counters. A counter climbs one step for each correct prediction and drops straight to zero on any miss.

The table is indexed gshare style. The instruction address, without its two alignment bits, is XORed with a history register held for each hardware context. That register records the last outcomes, one bit each: 1 for a miss and 0 for a correct prediction. The lookup is combinational and also returns the history it used. The core keeps that snapshot with the branch and hands it back at resolution, so the update reaches the same entry the lookup read. The default table has 4096 entries of 3 bits, which is 12 Kbit. Setting the counter width parameter to 6 gives a 24 Kbit table, for designs that want fewer correct branches flagged.

Top module: `brconf_est`

## Requirements
- R1: Reset sets every counter to 0 and every context history to 0. After reset, each lookup returns low confidence and a history of 0.
- R2: The entry index is the address bits [13:2] XORed with the 12-bit history. A lookup uses the history of its own context. An update uses the history snapshot it is given.
- R3: A correct resolution adds 1 to the indexed counter. The counter holds at its maximum of 7 (2^CONF_W-1).
- R4: A mispredicted resolution sets the indexed counter to 0.
- R5: The verdict is low (lk_low=1) exactly when the counter is below THRESH, which defaults to 7. From reset, a branch therefore needs seven correct resolutions before it reads high confidence.
- R6: A resolution shifts its miss flag into bit 0 of its own context's history, and the oldest bit drops out. Histories of other contexts do not change. lk_hist returns the current history of the looked-up context.
- R7: When a lookup and an update happen in the same cycle, the lookup returns the counter and history as they were before that update.
- R8: The update index comes from the supplied snapshot (up_hist), even when that snapshot differs from the context's current history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_ctx | input | CTX_W | Context of the lookup |
| lk_low | output | 1 | 1 = low confidence (hard to predict) |
| lk_hist | output | IDX_W | History used for this lookup, to be kept as the snapshot |
| up_valid | input | 1 | A resolution is presented this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_ctx | input | CTX_W | Context of the resolved branch |
| up_hist | input | IDX_W | History snapshot taken at lookup |
| up_miss | input | 1 | 1 = the prediction was wrong |

## Verification
A counter that is corrupted or sits at the wrong index shows at the ports on the next lookup that maps to that entry. It appears as a verdict that flips one resolution too early or too late, or as a branch that stays confident after a miss. A wrong history bit shows on lk_hist in the very next cycle for that context. It also moves every later lookup of that context to a different entry, so verdicts diverge from the expected ones within a few branches. The same-cycle case is exercised directly: a stale or forwarded value there changes lk_low in that cycle.

// File: rtl/brconf_est.sv
module brconf_est #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 12,
  parameter int CONF_W = 3,
  parameter int NCTX   = 2,
  parameter int THRESH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [$clog2(NCTX)-1:0] lk_ctx,
  output logic              lk_low,
  output logic [IDX_W-1:0]  lk_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [$clog2(NCTX)-1:0] up_ctx,
  input  logic [IDX_W-1:0]  up_hist,
  input  logic              up_miss
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CTX_W = $clog2(NCTX);
  localparam logic [CONF_W-1:0] CMAX = {CONF_W{1'b1}};

  logic [CONF_W-1:0] tbl [DEPTH];
  logic [IDX_W-1:0]  hist [NCTX];
  logic [IDX_W-1:0]  lidx, uidx;
  logic [CONF_W-1:0] lval;

  assign lk_hist = hist[lk_ctx];
  assign lidx    = lk_pc[IDX_W+1:2] ^ lk_hist;
  assign uidx    = up_pc[IDX_W+1:2] ^ up_hist;
  assign lval    = tbl[lidx];
  assign lk_low  = (32'(lval) < THRESH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (up_valid) begin
      if (up_miss)                tbl[uidx] <= '0;
      else if (tbl[uidx] != CMAX) tbl[uidx] <= tbl[uidx] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCTX; c++) hist[c] <= '0;
    end else if (up_valid) begin
      hist[up_ctx] <= {hist[up_ctx][IDX_W-2:0], up_miss};
    end
  end

  // R4: a miss leaves its entry at zero
  p_miss_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_miss) |=> (tbl[$past(uidx)] == '0));

  // R3: a correct resolution never leaves its entry at zero
  p_inc_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_miss) |=> (tbl[$past(uidx)] != '0));

  // R3: saturated entry holds on further correct resolutions
  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_miss && tbl[uidx] == CMAX) |=> (tbl[$past(uidx)] == CMAX));

  // R6: newest history bit equals the resolved miss flag
  p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (hist[$past(up_ctx)][0] == $past(up_miss)));

  for (genvar c = 0; c < NCTX; c++) begin : g_hchk
    // R6: other contexts keep their history
    p_hist_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_valid && up_ctx == CTX_W'(c)) |=> $stable(hist[c]));
  end
endmodule

// File: tb/brconf_est_tb.sv
module brconf_est_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_pc = 0, up_pc = 0;
  logic        lk_ctx = 0, up_ctx = 0;
  logic        lk_low;
  logic [11:0] lk_hist, up_hist = 0;
  logic        up_valid = 0, up_miss = 0;

  int checks = 0, errors = 0;
  int mt [4096];
  logic [11:0] mh [2];
  bit done = 0;

  always #5 clk = ~clk;

  brconf_est u_dut (.clk, .rst_n, .lk_pc, .lk_ctx, .lk_low, .lk_hist,
                    .up_valid, .up_pc, .up_ctx, .up_hist, .up_miss);

  function automatic logic [11:0] fidx(logic [31:0] pc, logic [11:0] h);
    return pc[13:2] ^ h;
  endfunction

  function automatic bit exp_low(int c);
    return c < 7;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [31:0] lpc, logic lc, logic uv, logic [31:0] upc,
                      logic uc, logic [11:0] uh, logic um, string tag);
    logic [11:0] e;
    @(negedge clk);
    lk_pc = lpc; lk_ctx = lc; up_valid = uv; up_pc = upc; up_ctx = uc;
    up_hist = uh; up_miss = um;
    #1;
    e = fidx(lpc, mh[lc]);
    chk({tag, " verdict"}, 32'(lk_low), 32'(exp_low(mt[e])));
    chk({tag, " history"}, 32'(lk_hist), 32'(mh[lc]));
    if (uv) begin
      e = fidx(upc, uh);
      mt[e] = um ? 0 : (mt[e] < 7 ? mt[e] + 1 : 7);
      mh[uc] = {mh[uc][10:0], um};
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] p, q;
    void'($urandom(32'd1234));
    foreach (mt[i]) mt[i] = 0;
    mh[0] = 0; mh[1] = 0;
    repeat (3) @(negedge clk);
    // R1: during and right after reset
    lk_pc = 32'h40; #1;
    chk("R1 reset verdict", 32'(lk_low), 1);
    chk("R1 reset history", 32'(lk_hist), 0);
    rst_n = 1;
    step(32'h1234, 0, 0, 0, 0, 0, 0, "R1");
    step(32'hFFFC, 1, 0, 0, 0, 0, 0, "R1");

    // R5/R3: ctx0 looks up P while ctx1 resolves it correctly with snapshot 0
    p = 32'h100;
    for (int i = 0; i < 7; i++) step(p, 0, 1, p, 1, 0, 0, "R5");
    step(p, 0, 0, 0, 0, 0, 0, "R5");               // counter 7: high
    for (int i = 0; i < 3; i++) step(p, 0, 1, p, 1, 0, 0, "R3");
    // R7: same-cycle miss, lookup sees old high value
    step(p, 0, 1, p, 1, 0, 1, "R7");
    step(p, 0, 0, 0, 0, 0, 0, "R4");               // now low
    // R6: ctx1 history carries the miss, ctx0 still zero
    step(p, 1, 0, 0, 0, 0, 0, "R6");
    step(p, 0, 0, 0, 0, 0, 0, "R6");
    // retrain P with snapshot 0, then alias through ctx1 history (R2)
    for (int i = 0; i < 7; i++) step(p, 0, 1, p, 0, 0, 0, "R8");
    q = 32'({p[13:2] ^ mh[1]} << 2);
    step(q, 1, 0, 0, 0, 0, 0, "R2");
    // R8: update with a snapshot unlike current history
    step(p, 0, 1, 32'h200, 1, 12'hABC, 1, "R8");
    step(32'({fidx(32'h200, 12'hABC) ^ mh[0]} << 2), 0, 0, 0, 0, 0, 0, "R8");

    // random mix, a few branches so entries train
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] lp, up;
      logic lc, uc, uv, um;
      logic [11:0] uh;
      lp = 32'(($urandom % 8) * 4 + 32'h3000);
      up = 32'(($urandom % 8) * 4 + 32'h3000);
      lc = 1'($urandom); uc = 1'($urandom);
      uv = ($urandom % 4) != 0;
      um = ($urandom % 10) == 0;
      uh = ($urandom % 3 == 0) ? 12'($urandom % 4) : mh[uc];
      step(lp, lc, uv, up, uc, uh, um, "R2 R3 R4 R5 R6 R7");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule